// File: doc/BRIEF.md
# Timeout Device Power State Controller

This controller sits beside one device and decides when that device is running, idling with its clock stopped, or powered down. A single activity input tells it whether the device has work. Once the device has been quiet for a programmable number of cycles, the controller starts a shutdown. The shutdown and the later wakeup each last a programmable number of cycles, and the device cannot accept work during either one. A ready output tells the requester when work may be issued again.

The controller also keeps two statistics for the power-management software. The first counts every shutdown it starts. The second counts the shutdowns that did not pay off. A shutdown does not pay off when the device stayed asleep for fewer cycles than a programmable break-even threshold, or when the shutdown was cut short by a request before sleep began.

All timeouts and delays are given in clock cycles. Each is held in a down-counter that loads the programmed value when its phase begins. A programmed value of 0 behaves the same as 1.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset the state is RUN, ready is 1, both gate enables are 0, and both counts are 0.
- R2: In RUN, a low busy input moves the state to IDLE at the next clock edge. In IDLE, a high busy input moves the state back to RUN at the next edge, and no shutdown is counted.
- R3: After max(idleTimeout,1) consecutive cycles in IDLE with busy low, the state moves to SHUTDOWN. On that same edge, shutdownCount goes up by one.
- R4: SHUTDOWN lasts exactly max(shutdownDelay,1) cycles, whatever busy does during it. The state then moves to SLEEP if busy was never seen high during the shutdown, and to WAKEUP otherwise, even if busy was high for only one cycle.
- R5: SLEEP holds for as long as busy stays low. A high busy input in SLEEP moves the state to WAKEUP at the next edge.
- R6: WAKEUP lasts exactly max(wakeupDelay,1) cycles and then moves to RUN. Ready is 1 only in RUN.
- R7: The state output uses these codes: RUN=0, IDLE=1, SHUTDOWN=2, SLEEP=3, WAKEUP=4. clkGateEn is 1 in IDLE and in SLEEP. pwrGateEn is 1 only in SLEEP.
- R8: When SLEEP is left, wrongCount goes up by one if the number of cycles spent in SLEEP is less than breakEven. A shutdown that goes straight to WAKEUP counts as a sleep of 0 cycles, so it is wrong whenever breakEven is greater than 0.
- R9: shutdownCount and wrongCount each stop at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | Device has work or a request is pending |
| idleTimeout | input | CNT_W | Idle cycles allowed before a shutdown starts |
| shutdownDelay | input | CNT_W | Length of the shutdown phase, in cycles |
| wakeupDelay | input | CNT_W | Length of the wakeup phase, in cycles |
| breakEven | input | SLP_W | Shortest sleep, in cycles, that is not counted as wrong |
| state | output | 3 | Current state code |
| pwrGateEn | output | 1 | Power gate enable |
| clkGateEn | output | 1 | Clock gate enable |
| ready | output | 1 | Device can accept work |
| shutdownCount | output | STAT_W | Number of shutdowns started (saturating) |
| wrongCount | output | STAT_W | Number of shutdowns that did not pay off (saturating) |

## Verification
The hardest case to reach is a request that arrives during a shutdown but is already gone when the shutdown ends. Only a remembered request can then force a wakeup. The bench reaches this case by dropping busy, waiting for the SHUTDOWN code, and raising busy for a single cycle at the first SHUTDOWN sample. This needs a shutdown delay of at least 2. The bench then checks that the state passes through WAKEUP and not SLEEP, and that wrongCount follows breakEven. The main sweep covers every small combination of timeout, delays and sleep length, so the comparison against breakEven is tested on both sides of the threshold.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_SHDN  = 3'd2,
    ST_SLEEP = 3'd3,
    ST_WAKE  = 3'd4
  } pwrState_t;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic loadIdle;
    logic loadShdn;
    logic loadWake;
    logic decCnt;
    logic clrSleep;
    logic incSleep;
    logic incShutdown;
    logic markSleepExit;
    logic markAbort;
  } dpCtl_t;

endpackage

// File: rtl/pwr_ctl_dp.sv
module pwr_ctl_dp
  import pwr_ctl_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SLP_W  = 20,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [CNT_W-1:0]  idleTimeout,
  input  logic [CNT_W-1:0]  shutdownDelay,
  input  logic [CNT_W-1:0]  wakeupDelay,
  input  logic [SLP_W-1:0]  breakEven,
  output logic              cntLast,
  output logic [STAT_W-1:0] shutdownCount,
  output logic [STAT_W-1:0] wrongCount
);

  logic [CNT_W-1:0] phaseCnt;
  logic [SLP_W-1:0] sleepLen;
  logic [SLP_W:0]   sleepDur;
  logic             wrongHit;

  // One down-counter shared by the idle, shutdown and wakeup phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (ctl.loadIdle)     phaseCnt <= idleTimeout;
    else if (ctl.loadShdn)     phaseCnt <= shutdownDelay;
    else if (ctl.loadWake)     phaseCnt <= wakeupDelay;
    else if (ctl.decCnt && phaseCnt != '0) phaseCnt <= phaseCnt - 1'b1;
  end

  assign cntLast = (phaseCnt <= CNT_W'(1));

  // Length of the current sleep, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   sleepLen <= '0;
    else if (ctl.clrSleep)                       sleepLen <= '0;
    else if (ctl.incSleep && sleepLen != '1)     sleepLen <= sleepLen + 1'b1;
  end

  assign sleepDur = {1'b0, sleepLen} + 1'b1;

  always_comb begin
    if (ctl.markSleepExit)  wrongHit = (sleepDur < {1'b0, breakEven});
    else if (ctl.markAbort) wrongHit = (breakEven != '0);
    else                    wrongHit = 1'b0;
  end

  // Saturating statistics counters
  logic [1:0] statInc;
  logic [STAT_W-1:0] statVal [2];
  assign statInc = {wrongHit, ctl.incShutdown};

  for (genvar g = 0; g < 2; g++) begin : gStat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   statVal[g] <= '0;
      else if (statInc[g] && statVal[g] != '1)     statVal[g] <= statVal[g] + 1'b1;
    end
  end

  assign shutdownCount = statVal[0];
  assign wrongCount    = statVal[1];

endmodule

// File: rtl/pwr_ctl_fsm.sv
module pwr_ctl_fsm
  import pwr_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busy,
  input  logic      cntLast,
  output pwrState_t curState,
  output dpCtl_t    ctl
);

  pwrState_t nextState;
  logic      reqPending;

  always_comb begin
    nextState = curState;
    ctl       = '0;
    unique case (curState)
      ST_RUN: begin
        if (!busy) begin
          nextState    = ST_IDLE;
          ctl.loadIdle = 1'b1;
        end
      end
      ST_IDLE: begin
        if (busy) begin
          nextState = ST_RUN;
        end else if (cntLast) begin
          nextState       = ST_SHDN;
          ctl.loadShdn    = 1'b1;
          ctl.incShutdown = 1'b1;
        end else begin
          ctl.decCnt = 1'b1;
        end
      end
      ST_SHDN: begin
        if (cntLast) begin
          if (reqPending || busy) begin
            nextState     = ST_WAKE;
            ctl.loadWake  = 1'b1;
            ctl.markAbort = 1'b1;
          end else begin
            nextState    = ST_SLEEP;
            ctl.clrSleep = 1'b1;
          end
        end else begin
          ctl.decCnt = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (busy) begin
          nextState         = ST_WAKE;
          ctl.loadWake      = 1'b1;
          ctl.markSleepExit = 1'b1;
        end else begin
          ctl.incSleep = 1'b1;
        end
      end
      ST_WAKE: begin
        if (cntLast) nextState  = ST_RUN;
        else         ctl.decCnt = 1'b1;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState   <= ST_RUN;
      reqPending <= 1'b0;
    end else begin
      curState   <= nextState;
      reqPending <= (curState == ST_SHDN && nextState == ST_SHDN) ? (reqPending | busy) : 1'b0;
    end
  end

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_ctl_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SLP_W  = 20,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic [CNT_W-1:0]  idleTimeout,
  input  logic [CNT_W-1:0]  shutdownDelay,
  input  logic [CNT_W-1:0]  wakeupDelay,
  input  logic [SLP_W-1:0]  breakEven,
  output logic [2:0]        state,
  output logic              pwrGateEn,
  output logic              clkGateEn,
  output logic              ready,
  output logic [STAT_W-1:0] shutdownCount,
  output logic [STAT_W-1:0] wrongCount
);

  pwrState_t curState;
  dpCtl_t    ctl;
  logic      cntLast;

  pwr_ctl_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .busy     (busy),
    .cntLast  (cntLast),
    .curState (curState),
    .ctl      (ctl)
  );

  pwr_ctl_dp #(
    .CNT_W  (CNT_W),
    .SLP_W  (SLP_W),
    .STAT_W (STAT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .idleTimeout   (idleTimeout),
    .shutdownDelay (shutdownDelay),
    .wakeupDelay   (wakeupDelay),
    .breakEven     (breakEven),
    .cntLast       (cntLast),
    .shutdownCount (shutdownCount),
    .wrongCount    (wrongCount)
  );

  assign state     = curState;
  assign ready     = (curState == ST_RUN);
  assign clkGateEn = (curState == ST_IDLE) || (curState == ST_SLEEP);
  assign pwrGateEn = (curState == ST_SLEEP);

endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk #(
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic [2:0]        state,
  input logic              pwrGateEn,
  input logic              clkGateEn,
  input logic              ready,
  input logic [STAT_W-1:0] shutdownCount,
  input logic [STAT_W-1:0] wrongCount
);

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R3: a shutdown can only begin from IDLE
  a_r3_shdn_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && state == 3'd2 && $past(state) != 3'd2) |-> ($past(state) == 3'd1));

  // R3: shutdownCount moves only on the edge that enters SHUTDOWN from IDLE
  a_r3_count_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && shutdownCount != $past(shutdownCount)) |-> (state == 3'd2 && $past(state) == 3'd1));

  // R5: SLEEP is left only for WAKEUP, and only after busy was high
  a_r5_sleep_exit: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(state) == 3'd3 && state != 3'd3) |-> (state == 3'd4 && $past(busy)));

  // R6: ready comes back only from WAKEUP or IDLE
  a_r6_ready_source: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $rose(ready)) |-> ($past(state) == 3'd4 || $past(state) == 3'd1));

  // R7: power gating implies clock gating and no readiness
  a_r7_gate_order: assert property (@(posedge clk) disable iff (!rstN)
    pwrGateEn |-> (clkGateEn && !ready));

  // R8: a wrong shutdown must follow a counted shutdown
  a_r8_wrong_bounded: assert property (@(posedge clk) disable iff (!rstN)
    wrongCount <= shutdownCount);

endmodule

bind pwr_state_ctl pwr_state_ctl_chk #(.STAT_W(STAT_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .busy          (busy),
  .state         (state),
  .pwrGateEn     (pwrGateEn),
  .clkGateEn     (clkGateEn),
  .ready         (ready),
  .shutdownCount (shutdownCount),
  .wrongCount    (wrongCount)
);

// File: tb/tb_pwr_state_ctl.sv
module tb_pwr_state_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int SLP_W  = 8;
  localparam int STAT_W = 3;

  localparam logic [2:0] S_RUN = 3'd0, S_IDLE = 3'd1, S_SHDN = 3'd2,
                         S_SLEEP = 3'd3, S_WAKE = 3'd4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busy = 1'b1;
  logic [CNT_W-1:0]  idleTimeout = '0;
  logic [CNT_W-1:0]  shutdownDelay = '0;
  logic [CNT_W-1:0]  wakeupDelay = '0;
  logic [SLP_W-1:0]  breakEven = '0;
  logic [2:0]        state;
  logic              pwrGateEn, clkGateEn, ready;
  logic [STAT_W-1:0] shutdownCount, wrongCount;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctl #(.CNT_W(CNT_W), .SLP_W(SLP_W), .STAT_W(STAT_W)) dut (
    .clk(clk), .rstN(rstN), .busy(busy),
    .idleTimeout(idleTimeout), .shutdownDelay(shutdownDelay),
    .wakeupDelay(wakeupDelay), .breakEven(breakEven),
    .state(state), .pwrGateEn(pwrGateEn), .clkGateEn(clkGateEn),
    .ready(ready), .shutdownCount(shutdownCount), .wrongCount(wrongCount)
  );

  function automatic int atLeast1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // R7 output encoding for a given state
  task automatic checkGates(input logic [2:0] s);
    checkEq("R7 state code", int'(state), int'(s));
    checkEq("R7 clkGateEn", int'(clkGateEn), int'(s == S_IDLE || s == S_SLEEP));
    checkEq("R7 pwrGateEn", int'(pwrGateEn), int'(s == S_SLEEP));
    checkEq("R6 ready", int'(ready), int'(s == S_RUN));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    busy = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic countState(input logic [2:0] s, output int n);
    n = 0;
    while (state == s && n < 600) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Full cycle RUN -> IDLE -> SHDN -> SLEEP(h) -> WAKE -> RUN
  task automatic sleepRun(input int to, input int sd, input int wu, input int be, input int h);
    int n;
    idleTimeout = CNT_W'(to); shutdownDelay = CNT_W'(sd);
    wakeupDelay = CNT_W'(wu); breakEven = SLP_W'(be);
    doReset();
    busy = 1'b0;
    @(negedge clk);
    checkGates(S_IDLE);                                       // R2
    countState(S_IDLE, n);
    checkEq("R3 idle length", n, atLeast1(to));
    checkGates(S_SHDN);
    checkEq("R3 shutdownCount", int'(shutdownCount), 1);
    countState(S_SHDN, n);
    checkEq("R4 shutdown length", n, atLeast1(sd));
    checkGates(S_SLEEP);
    repeat (h - 1) @(negedge clk);
    checkEq("R5 sleep holds", int'(state), int'(S_SLEEP));
    busy = 1'b1;
    @(negedge clk);
    checkGates(S_WAKE);                                       // R5
    countState(S_WAKE, n);
    checkEq("R6 wake length", n, atLeast1(wu));
    checkGates(S_RUN);
    checkEq("R8 wrongCount", int'(wrongCount), int'(h < be));
  endtask

  // Request during shutdown, held or single-cycle pulse
  task automatic abortRun(input int sd, input int be, input bit pulse);
    int n;
    idleTimeout = 8'd1; shutdownDelay = CNT_W'(sd);
    wakeupDelay = 8'd2; breakEven = SLP_W'(be);
    doReset();
    busy = 1'b0;
    repeat (2) @(negedge clk);
    checkEq("R4 in shutdown", int'(state), int'(S_SHDN));
    busy = 1'b1;
    if (pulse) begin
      @(negedge clk);
      busy = 1'b0;
    end
    countState(S_SHDN, n);
    checkEq("R4 shutdown length with request", n + int'(pulse), atLeast1(sd));
    checkEq("R4 request goes to wake", int'(state), int'(S_WAKE));
    countState(S_WAKE, n);
    checkEq("R6 wake length after abort", n, 2);
    checkEq("R6 run after abort", int'(state), int'(S_RUN));
    checkEq("R8 abort wrongCount", int'(wrongCount), int'(be > 0));
    checkEq("R3 abort shutdownCount", int'(shutdownCount), 1);
  endtask

  task automatic idleBack(input int m);
    idleTimeout = 8'd5; shutdownDelay = 8'd1; wakeupDelay = 8'd1; breakEven = '0;
    doReset();
    busy = 1'b0;
    repeat (m) @(negedge clk);
    checkEq("R2 still idle", int'(state), int'(S_IDLE));
    busy = 1'b1;
    @(negedge clk);
    checkGates(S_RUN);                                        // R2
    checkEq("R2 no shutdown counted", int'(shutdownCount), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    checkGates(S_RUN);
    checkEq("R1 shutdownCount", int'(shutdownCount), 0);
    checkEq("R1 wrongCount", int'(wrongCount), 0);

    for (int to = 0; to <= 2; to++)
      for (int sd = 0; sd <= 2; sd++)
        for (int wu = 0; wu <= 2; wu++)
          for (int h = 1; h <= 3; h++)
            sleepRun(to, sd, wu, 2, h);

    sleepRun(3, 1, 1, 0, 1);
    sleepRun(1, 3, 2, 5, 5);
    sleepRun(1, 1, 3, 5, 4);

    for (int sd = 1; sd <= 3; sd++)
      for (int be = 0; be <= 1; be++)
        abortRun(sd, be, 1'b0);
    for (int sd = 2; sd <= 4; sd++)
      abortRun(sd, 1, 1'b1);

    for (int m = 1; m <= 4; m++)
      idleBack(m);

    // R9 saturation with STAT_W = 3
    idleTimeout = 8'd1; shutdownDelay = 8'd1; wakeupDelay = 8'd1; breakEven = 8'd3;
    doReset();
    for (int k = 1; k <= 10; k++) begin
      busy = 1'b0;
      repeat (3) @(negedge clk);
      busy = 1'b1;
      repeat (2) @(negedge clk);
      if (k == 5) begin
        checkEq("R9 shutdownCount mid", int'(shutdownCount), 5);
        checkEq("R9 wrongCount mid", int'(wrongCount), 5);
      end
    end
    checkEq("R9 shutdownCount saturates", int'(shutdownCount), 7);
    checkEq("R9 wrongCount saturates", int'(wrongCount), 7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule